// File: doc/BRIEF.md
# Banked Aperture Address Mapper

This block turns CPU accesses that land in a 64 KB legacy memory window into byte addresses in a larger video memory. The window is split into a lower and an upper 32 KB half, each served by its own bank. Each bank has a base and a limit. Both are derived from an 8-bit offset register, a mode register and the installed memory size, which is fixed at build time.

Software programs two offset registers and a mode register through a small byte-wide write port. The mode register selects between two schemes:
- Dual-bank: each half of the window uses its own offset register.
- Single-bank: both halves share offset register 0, and the upper half sits 32 KB further into memory.

The offset unit is either 4 KB or 16 KB. Base and limit are kept in registers that follow the programming registers one cycle later. Every access is mapped combinationally from those registers. An access that falls outside its bank's limit is flagged. It never reaches memory, and a read of it returns all ones.

Top module: `banked_aperture_mapper`

## Requirements
- R1: After reset both offsets are 0 and the mode is single-bank with 4 KB units. Window address A then maps to memory address A for every A in 0x0000..0xFFFF.
- R2: When `cfg_we` is high at a clock edge, the register chosen by `cfg_sel` is written: 0 is offset 0, 1 is offset 1, 2 is the mode register. Mode bit 0 set means dual-bank, and mode bit 1 set means 16 KB units. A write with `cfg_sel` = 3 changes nothing.
- R3: The shifted offset is the 8-bit offset shifted left by 12 bits with 4 KB units, or by 14 bits with 16 KB units.
- R4: Window address bit 15 picks bank 0 (clear) or bank 1 (set). Bits 14..0 are added to that bank's base to form `mem_addr`. In dual-bank mode, bank n uses offset register n.
- R5: In single-bank mode both banks use offset 0, and bank 1's base is the shifted offset plus 0x8000.
- R6: A bank's limit is memory size minus its shifted offset. The limit is 0 when the shifted offset is at or above memory size.
- R7: In single-bank mode, bank 1's limit is the bank 0 limit minus 0x8000 when that limit exceeds 0x8000, and 0 otherwise (including exactly 0x8000).
- R8: A bank whose limit is 0 has its base forced to 0. `mem_addr` then equals the low 15 window bits.
- R9: An access with an in-bank offset at or above its bank's limit raises `acc_oor` and holds `mem_req` and `mem_we` low, so a write is dropped. If the access is a read, `acc_rdata` returns all ones.
- R10: A register write at clock edge k affects mapping from edge k+1 onward. An access in the cycle between those edges is mapped with the old values.
- R11: An in-range access raises `mem_req`, passes `acc_we` and `acc_wdata` through to memory, and returns `mem_rdata` on `acc_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 offset 0, 1 offset 1, 2 mode |
| cfg_wdata | input | OFF_W | Register write data |
| acc_valid | input | 1 | Window access present |
| acc_we | input | 1 | Window access is a write |
| acc_addr | input | WIN_AW | Address inside the window |
| acc_wdata | input | DATA_W | Write data of the access |
| acc_rdata | output | DATA_W | Read data back to the CPU |
| acc_oor | output | 1 | Access falls outside its bank limit |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | MA_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
A wrong base register shows up as a shifted `mem_addr` on the very first access to that half of the window. A wrong limit shows up as a false or missing `acc_oor`, a stray `mem_req`, or a read that returns memory data instead of all ones. A register update that is late or early by one cycle is exposed by accesses placed in the cycle directly after a register write. The bench therefore compares every mapping output each clock against a behavioural model that keeps its own copy of the registers, delayed by one cycle.

// File: rtl/banked_aperture_mapper.sv
module banked_aperture_mapper #(
  parameter int MEM_BYTES = 32'h0020_0000,
  parameter int OFF_W     = 8,
  parameter int FINE_SH   = 12,
  parameter int COARSE_SH = 14,
  parameter int WIN_AW    = 16,
  parameter int DATA_W    = 8,
  localparam int HALF_AW  = WIN_AW - 1,
  localparam int MA_W     = OFF_W + COARSE_SH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [OFF_W-1:0]  cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [WIN_AW-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_oor,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [MA_W-1:0] MEM_MA  = MA_W'(MEM_BYTES);
  localparam logic [MA_W-1:0] HALF_MA = MA_W'(1) << HALF_AW;

  logic [OFF_W-1:0] off_q [2];
  logic             dual_q, coarse_q;
  logic [MA_W-1:0]  base_v [2];
  logic [MA_W-1:0]  lim_v  [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q[0] <= '0;
      off_q[1] <= '0;
      dual_q   <= 1'b0;
      coarse_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: off_q[0] <= cfg_wdata;
        2'd1: off_q[1] <= cfg_wdata;
        2'd2: begin
          dual_q   <= cfg_wdata[0];
          coarse_q <= cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [MA_W-1:0] RST_BASE = (b == 1) ? HALF_MA : '0;
    localparam logic [MA_W-1:0] RST_LIM  = (b == 1) ? MEM_MA - HALF_MA : MEM_MA;
    logic [OFF_W-1:0] o;
    logic [MA_W-1:0]  sh, nb, nl, base_q, lim_q;

    always_comb begin
      o  = dual_q ? off_q[b] : off_q[0];
      sh = coarse_q ? (MA_W'(o) << COARSE_SH) : (MA_W'(o) << FINE_SH);
      nl = (sh >= MEM_MA) ? '0 : MEM_MA - sh;
      nb = sh;
      if (b == 1 && !dual_q) begin
        if (nl > HALF_MA) begin
          nb = sh + HALF_MA;
          nl = nl - HALF_MA;
        end else begin
          nl = '0;
        end
      end
      if (nl == '0) nb = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q <= RST_BASE;
        lim_q  <= RST_LIM;
      end else begin
        base_q <= nb;
        lim_q  <= nl;
      end
    end

    assign base_v[b] = base_q;
    assign lim_v[b]  = lim_q;
  end

  logic            sel;
  logic [MA_W-1:0] in_ext;

  assign sel       = acc_addr[WIN_AW-1];
  assign in_ext    = MA_W'(acc_addr[HALF_AW-1:0]);
  assign acc_oor   = acc_valid && (in_ext >= lim_v[sel]);
  assign mem_addr  = base_v[sel] + in_ext;
  assign mem_req   = acc_valid && !acc_oor;
  assign mem_we    = mem_req && acc_we;
  assign mem_wdata = acc_wdata;
  assign acc_rdata = acc_oor ? '1 : mem_rdata;
endmodule

// File: rtl/aperture_mapper_chk.sv
module aperture_mapper_chk #(
  parameter int MEM_BYTES = 32'h0020_0000,
  parameter int WIN_AW    = 16,
  parameter int MA_W      = 23,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              acc_valid,
  input logic              acc_we,
  input logic [WIN_AW-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              acc_oor,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MA_W-1:0]   mem_addr
);
  AST_OOR_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_oor |-> (!mem_req && !mem_we)); // R9
  AST_OOR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_oor && !acc_we) |-> (acc_rdata == '1)); // R9
  AST_ADDR_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr < MA_W'(MEM_BYTES))); // R6
  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && $past(acc_valid) && $stable(acc_addr) && !$past(cfg_we) && !$past(cfg_we, 2))
      |-> ($stable(mem_addr) && $stable(acc_oor))); // R10
endmodule

bind banked_aperture_mapper aperture_mapper_chk #(
  .MEM_BYTES(MEM_BYTES), .WIN_AW(WIN_AW), .MA_W(MA_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .acc_valid(acc_valid), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_rdata(acc_rdata), .acc_oor(acc_oor), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/sim_banked_aperture_mapper.sv
module sim_banked_aperture_mapper;
  localparam int PERIOD = 10;
  localparam longint MEM = 64'h20_0000;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, acc_valid = 0, acc_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0, acc_wdata = 0, acc_rdata, mem_wdata, mem_rdata;
  logic [15:0] acc_addr = 0;
  logic acc_oor, mem_req, mem_we;
  logic [22:0] mem_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  int c_off0 = 0, c_off1 = 0, c_dual = 0, c_coarse = 0;
  int e_off0 = 0, e_off1 = 0, e_dual = 0, e_coarse = 0;

  always #(PERIOD/2) clk = ~clk;
  assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

  banked_aperture_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_oor(acc_oor), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit cw, bit [1:0] cs, bit [7:0] cd, bit v, bit w, bit [15:0] a, string tag);
    longint sh, lim, base, eaddr, inb;
    int o, b;
    bit oor;
    cfg_we = cw; cfg_sel = cs; cfg_wdata = cd;
    acc_valid = v; acc_we = w; acc_addr = a; acc_wdata = a[7:0] ^ 8'h33;
    #1;
    b = a[15];
    inb = a & 16'h7FFF;
    o = (e_dual != 0 && b == 1) ? e_off1 : e_off0;
    sh = longint'(o) << (e_coarse != 0 ? 14 : 12);
    lim = (sh >= MEM) ? 0 : MEM - sh;
    base = sh;
    if (b == 1 && e_dual == 0) begin
      if (lim > 32768) begin base = sh + 32768; lim = lim - 32768; end
      else lim = 0;
    end
    if (lim == 0) base = 0;
    eaddr = base + inb;
    oor = v && (inb >= lim);
    if (v) begin
      chk(tag, "mem_addr", mem_addr, eaddr);
      chk(tag, "acc_oor", acc_oor, oor);
      chk(tag, "mem_req", mem_req, !oor);
      chk(tag, "mem_we", mem_we, !oor && w);
      if (!w) chk(tag, "acc_rdata", acc_rdata, oor ? 8'hFF : (eaddr[7:0] ^ 8'h5A));
      else if (!oor) chk(tag, "mem_wdata", mem_wdata, a[7:0] ^ 8'h33);
    end else begin
      chk(tag, "mem_req idle", mem_req, 0);
    end
    @(posedge clk);
    e_off0 = c_off0; e_off1 = c_off1; e_dual = c_dual; e_coarse = c_coarse;
    if (cw && rst_n) begin
      case (cs)
        2'd0: c_off0 = cd;
        2'd1: c_off1 = cd;
        2'd2: begin c_dual = cd[0]; c_coarse = cd[1]; end
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(bit [1:0] s, bit [7:0] d, string tag);
    cyc(1, s, d, 0, 0, 0, tag);
    cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(0, 0, 0, 1, 0, 16'h0000, "R1");
    cyc(0, 0, 0, 1, 0, 16'h7FFF, "R1");
    cyc(0, 0, 0, 1, 0, 16'h8000, "R1");
    cyc(0, 0, 0, 1, 0, 16'hFFFF, "R1");
    wr(0, 8'h10, "R2");
    cyc(0, 0, 0, 1, 0, 16'h1234, "R3");
    cyc(0, 0, 0, 1, 0, 16'h8004, "R5");
    cyc(0, 0, 0, 1, 1, 16'h0042, "R11");
    wr(3, 8'hFF, "R2");
    cyc(0, 0, 0, 1, 0, 16'h1234, "R2");
    cyc(0, 0, 0, 1, 0, 16'h8004, "R2");
    wr(2, 8'h02, "R3");
    cyc(0, 0, 0, 1, 0, 16'h1234, "R3");
    cyc(0, 0, 0, 1, 0, 16'h8004, "R5");
    wr(1, 8'h20, "R2");
    wr(2, 8'h03, "R4");
    cyc(0, 0, 0, 1, 0, 16'h8001, "R4");
    cyc(0, 0, 0, 1, 0, 16'h0005, "R4");
    cyc(1, 1, 8'h30, 1, 0, 16'h8000, "R10");
    cyc(0, 0, 0, 1, 0, 16'h8000, "R10");
    cyc(0, 0, 0, 1, 0, 16'h8000, "R10");
    cyc(1, 2, 8'h02, 1, 0, 16'h8100, "R10");
    cyc(1, 0, 8'h7F, 1, 0, 16'h8100, "R10");
    cyc(0, 0, 0, 1, 0, 16'h3FFF, "R6");
    cyc(0, 0, 0, 1, 0, 16'h4000, "R9");
    cyc(0, 0, 0, 1, 1, 16'h4000, "R9");
    cyc(0, 0, 0, 1, 1, 16'h7FFF, "R9");
    cyc(0, 0, 0, 1, 0, 16'h8000, "R7");
    wr(0, 8'h80, "R6");
    cyc(0, 0, 0, 1, 0, 16'h0000, "R8");
    cyc(0, 0, 0, 1, 0, 16'h0123, "R8");
    wr(0, 8'h7C, "R7");
    cyc(0, 0, 0, 1, 0, 16'hFFFF, "R6");
    cyc(0, 0, 0, 1, 0, 16'h8000, "R7");
    wr(0, 8'h7B, "R7");
    cyc(0, 0, 0, 1, 0, 16'h8000, "R7");
    cyc(0, 0, 0, 1, 0, 16'hBFFF, "R7");
    cyc(0, 0, 0, 1, 0, 16'hC000, "R7");
    wr(2, 8'h00, "R3");
    cyc(0, 0, 0, 1, 0, 16'hFFFF, "R3");
    wr(2, 8'h03, "R4");
    wr(1, 8'h80, "R8");
    cyc(0, 0, 0, 1, 0, 16'h8077, "R8");
    cyc(0, 0, 0, 1, 1, 16'h8077, "R9");
    cyc(0, 0, 0, 1, 0, 16'h0777, "R4");
    wr(1, 8'h00, "R4");
    cyc(0, 0, 0, 1, 1, 16'h8123, "R11");
    cyc(0, 0, 0, 0, 0, 16'h0000, "R11");
    finish_run();
  end
endmodule